// File: doc/BRIEF.md
# SMBus Slave Register-Pointer Interface

This block is the serial front end of a device that exposes a small bank of 8-bit internal registers over a two-wire SMBus/I2C bus. The clock and data lines are brought into the system clock domain through two-flop synchronisers. Edges of the synchronised lines reveal start and stop conditions and the bit clock. The slave owns the data line only through an active-low pull enable, so the pad is open-drain.

The device address is captured during reset from a location strap that fills its low bits. The strap is never consulted again. Within a write transaction, the first byte after the address always loads a persistent pointer, and every later byte is written to the register that pointer selects. A read transaction returns register contents starting at the stored pointer, whether or not a pointer write came just before it. The pointer advances after every data byte and wraps at the top of the register space. The register bank sits outside the block and is reached through a plain address / write-data / write-strobe / read-data port.

Top module: `smb_regptr_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start; it begins address reception from any state, including in the middle of a transaction (repeated start with no stop).
- R2: The 8 bits after a start are a 7-bit address, MSB first, then a direction bit (1 = read). On a match the slave pulls SDA low during the 9th clock; on a mismatch it never pulls SDA and performs no register access until the next start.
- R3: The device address is {BASE_ADDR[6:LOC_W], loc_strap}, using the strap value present while rst is high; strap changes after reset have no effect.
- R4: In a write, the first byte after the address is loaded into the pointer (its low AW bits), is acknowledged, and produces no register write strobe.
- R5: Each later write byte is acknowledged and produces exactly one single-cycle reg_we with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R6: The pointer increments by one after every data byte written or read, and wraps from 2^AW-1 to 0.
- R7: A read sends the register at the pointer, MSB first; the pointer keeps its value between transactions, so a read with no pointer write continues from the last stored value.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and does not pull it again until the next start.
- R9: A rising SDA while SCL is high is a stop; it ends the transaction and leaves SDA released. After reset SDA is released and no write strobe is active.
- R10: The slave changes its SDA pull only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; strap is captured while high |
| loc_strap | input | LOC_W | Location strap selecting the low address bits |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull SDA low; 0 = release |
| reg_addr | output | AW | Register address (the pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr, one cycle latency allowed |

## Verification
The hardest situation to reach is one where stored state crosses transaction boundaries. One case is a pointer that wrapped inside one transaction and is then consumed by a read with no pointer write. The other is a pointer-only write followed by a repeated start into a read. The stimulus therefore mixes directed sequences at the top of the register space with random streams of pointer-only writes, multi-byte writes, bare reads and repeated-start reads. A bench model carries the pointer from one transaction to the next. Random addresses that miss the strap-selected address, including the address a changed strap would give, confirm that those transactions leave both the pointer and the registers untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= '1;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
  import smb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_bit,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [6:0]    dev_addr,
  input  logic [7:0]    rdata,
  output logic          pull,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wdata,
  output logic          we
);
  localparam logic [3:0] BITS = 4'd8;

  smb_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       dir_rd;
  logic       first_wr;
  logic       mack;
  logic [7:0] byte_in;

  assign byte_in = {shreg[6:0], sda_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      dir_rd   <= 1'b0;
      first_wr <= 1'b0;
      mack     <= 1'b0;
      pull     <= 1'b0;
      ptr      <= '0;
      wdata    <= '0;
      we       <= 1'b0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        pull   <= 1'b0;
      end else if (stop_ev) begin
        state <= ST_IDLE;
        pull  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && bitcnt < BITS) begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BITS) begin
              if (shreg[7:1] == dev_addr) begin
                pull   <= 1'b1;
                dir_rd <= shreg[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (dir_rd) begin
                shreg  <= rdata;
                pull   <= ~rdata[7];
                bitcnt <= 4'd1;
                state  <= ST_RD;
              end else begin
                pull     <= 1'b0;
                bitcnt   <= '0;
                first_wr <= 1'b1;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && bitcnt < BITS) begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BITS - 1) begin
                if (first_wr) begin
                  ptr      <= byte_in[AW-1:0];
                  first_wr <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  wdata <= byte_in;
                end
              end
            end else if (scl_fall && bitcnt == BITS) begin
              pull  <= 1'b1;
              state <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              pull   <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt < BITS) begin
                pull   <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end else begin
                pull  <= 1'b0;
                ptr   <= ptr + 1'b1;
                state <= ST_RD_ACK;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              if (mack) begin
                shreg  <= rdata;
                pull   <= ~rdata[7];
                bitcnt <= 4'd1;
                state  <= ST_RD;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_ADDR));
  a_r8_quiet_when_unselected: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE || state == ST_IDLE) |-> !pull);
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (!pull && state == ST_IDLE));
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);
  a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull) |-> !scl_lvl);
  a_r4_no_we_outside_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (state == ST_WR));
endmodule

// File: rtl/smb_regptr_slave.sv
module smb_regptr_slave
  import smb_pkg::*;
#(
  parameter int         AW        = 4,
  parameter int         LOC_W     = 2,
  parameter int         SYNC_LEN  = 2,
  parameter logic [6:0] BASE_ADDR = 7'h2C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOC_W-1:0] loc_strap,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic [AW-1:0]    reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);
  localparam int FIXED_W = 7 - LOC_W;

  logic [6:0] dev_addr;
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  always_ff @(posedge clk) begin
    if (rst) dev_addr <= {BASE_ADDR[6 -: FIXED_W], loc_strap};
  end

  smb_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  smb_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_xfer_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_s),
    .sda_bit  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .dev_addr (dev_addr),
    .rdata    (reg_rdata),
    .pull     (sda_pull),
    .ptr      (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we)
  );

  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dev_addr));
endmodule

// File: tb/smb_regptr_slave_tb_top.sv
module smb_regptr_slave_tb_top;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam int Q = 6;
  localparam logic [6:0] BASE = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] strap = 2'b01;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we;
  wire  sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  smb_regptr_slave #(.AW(AW), .LOC_W(2), .SYNC_LEN(2), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .loc_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 29 + 7);
  endfunction

  // register bank stub outside the block
  logic [7:0] mem [NREG];
  int wr_count;
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
      wr_count <= 0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
      reg_rdata <= mem[reg_addr];
    end
  end

  int nchk = 0, nfail = 0, viol = 0;
  logic [7:0] exp_mem [NREG];
  logic [AW-1:0] exp_ptr = '0;
  logic [6:0] dev;
  logic [7:0] wbuf [4];

  // R10 monitor: pull may move only while SCL is low
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_pull !== prev_pull && scl_m) viol++;
    prev_pull = sda_pull;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
    end
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(2*Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    ack = ~sda_line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      b[i] = sda_line; wait_q(Q);
      scl_m = 1'b0;
    end
    sda_m = ~do_ack; wait_q(Q);
    scl_m = 1'b1; wait_q(2*Q);
    scl_m = 1'b0; wait_q(1);
    sda_m = 1'b1;
  endtask

  // write: address, pointer byte, then n data bytes from wbuf
  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n, input logic do_stop);
    logic ack; logic hit; int wc0;
    hit = (a == dev);
    wc0 = wr_count;
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(ack == hit, "R2 address ack", ack, hit);
    if (hit) begin
      send_byte(p, ack);
      check(ack, "R4 pointer byte ack", ack, 1);
      exp_ptr = p[AW-1:0];
      for (int k = 0; k < n; k++) begin
        send_byte(wbuf[k], ack);
        check(ack, "R5 data byte ack", ack, 1);
        exp_mem[exp_ptr] = wbuf[k];
        exp_ptr = exp_ptr + 1'b1;
      end
    end
    if (do_stop) bus_stop();
    wait_q(2);
    check(wr_count - wc0 == (hit ? n : 0), "R4/R5 write strobe count", wr_count - wc0, hit ? n : 0);
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n);
    logic ack; logic hit; logic [7:0] b; logic seen_pull;
    hit = (a == dev);
    bus_start();
    send_byte({a, 1'b1}, ack);
    check(ack == hit, "R2 read address ack", ack, hit);
    if (hit) begin
      for (int k = 0; k < n; k++) begin
        recv_byte(k < n - 1, b);
        check(b == exp_mem[exp_ptr], "R7 read data", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 1'b1;
      end
      // R8: after the not-acknowledge the slave must stay off the line
      seen_pull = 1'b0;
      for (int i = 0; i < 2; i++) begin
        wait_q(Q); scl_m = 1'b1;
        for (int j = 0; j < 2*Q; j++) begin
          if (sda_pull) seen_pull = 1'b1;
          wait_q(1);
        end
        scl_m = 1'b0;
      end
      check(!seen_pull, "R8 released after master nack", seen_pull, 0);
    end
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < NREG; i++) exp_mem[i] = init_val(i);
    dev = {BASE[6:2], 2'b01};
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R9 reset pull released", sda_pull, 0);
    check(reg_we == 1'b0, "R9 reset no strobe", reg_we, 0);
    rst = 1'b0;
    wait_q(2);
    strap = 2'b10;   // R3: later strap change must not move the address
    wait_q(4);

    // R4 R5 R6: pointer then two data bytes
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    wr_txn(dev, 8'h03, 2, 1'b1);
    // R7: pointer-only write then separate read
    wr_txn(dev, 8'h03, 0, 1'b1);
    rd_txn(dev, 2);
    // R7: read without pointer write continues from stored pointer
    rd_txn(dev, 2);
    // R6: wrap at top of register space
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(dev, 8'h0F, 2, 1'b1);
    wr_txn(dev, 8'h0F, 0, 1'b1);
    rd_txn(dev, 3);
    // R3: address the new strap would select is not answered
    wbuf[0] = 8'hEE;
    wr_txn({BASE[6:2], 2'b10}, 8'h00, 1, 1'b1);
    rd_txn(dev, 1);
    // R1: pointer-only write, repeated start, read
    wr_txn(dev, 8'h07, 0, 1'b0);
    rd_txn(dev, 2);
    // R1: repeated start in the middle of a write data stream
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    wr_txn(dev, 8'h09, 2, 1'b0);
    wr_txn(dev, 8'h09, 0, 1'b0);
    rd_txn(dev, 2);

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a; int kind; int n;
      a = dev;
      if ($urandom % 4 == 0) begin
        a = 7'($urandom);
        if (a == dev) a = a ^ 7'h01;
      end
      kind = $urandom % 3;
      n = 1 + $urandom % 3;
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      case (kind)
        0: wr_txn(a, 8'($urandom), n, 1'b1);
        1: rd_txn(a, n);
        default: begin
          wr_txn(a, 8'($urandom), 0, 1'b0);
          rd_txn(a, n);
        end
      endcase
    end

    check(viol == 0, "R10 pull changed while SCL high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule